// File: doc/BRIEF.md
# Integer Clock Divider with Source Bypass

This block turns one of two incoming tick streams into a slower tick stream by an integer ratio. Everything runs on a single system clock: the crystal source, the fractional reference source and the divided output are all one-cycle enable pulses, not separate clocks. A small control register chooses the source, holds one divider field per source and gates the output. It can be written directly, or through set, clear and toggle aliases that touch only the bits written as 1.

Divider changes are made safe in two ways. While the output is gated, writes to the divider fields are refused. Otherwise a busy flag rises and stays up until the running output period has finished and the new ratio is in use. A change of source also waits for the end of the current period, so the output never shows a shortened interval. A divider of zero produces no output at all.

Top module: `clkdiv_bypass_top`

## Requirements
- R1: With source tick spacing S and selected divider D (nonzero), consecutive output ticks are exactly D*S clock cycles apart, so a window of M*D*S cycles that starts at an output tick holds exactly M output ticks.
- R2: While the divider in use is zero, no output tick is produced.
- R3: An accepted write that changes either divider field sets busy in the cycle after the write. Busy stays high until the running period ends, or at once if the output is gated or the running divider is zero, and then clears. A write that lands in the same cycle as a period end keeps busy set for one more full period, and that period still uses the old divider.
- R4: When the gate bit is 1 before a write, the write leaves both divider fields unchanged and does not set busy. The gate and bypass bits are still written.
- R5: While the gate bit is 1, no output tick is produced.
- R6: Bit 1 (bypass) set to 1 selects the crystal ticks with the divider in bits [7:2]. Set to 0 it selects the reference ticks with the divider in bits [13:8] (divider width 6).
- R7: wr_op encodes the write kind: 0 replaces the register, 1 ORs wr_data in, 2 clears the bits set in wr_data, 3 inverts the bits set in wr_data. Bit 0 is the gate.
- R8: A new source or divider takes effect only at the end of the current output period (or at once when gated or when the running divider is zero). The first interval after a switch to divider D with spacing S lies between (D-1)*S+1 and D*S cycles.
- R9: After reset the register reads gate 0, bypass 1 and both dividers 1, busy is 0 and no output tick is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | Crystal source enable pulse |
| ref_tick | input | 1 | Fractional reference enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Write kind: plain, set, clear, toggle |
| wr_data | input | 14 | Write data / bit mask |
| rd_data | output | 14 | Control register readback |
| busy | output | 1 | Divider update pending |
| tick_out | output | 1 | Divided output enable pulse |

## Verification
A divider write and the end of an output period can fall on the same clock edge. When they do, the period end loads the old register contents while the write stores the new value, and busy has to survive the load. The bench provokes this by timing the write one output period after an observed tick, so that it is sampled on the edge where the next tick is produced. It then confirms that a tick appears on that edge, that busy is still high, that the following interval still uses the old ratio, and that busy drops only at the next period end, after which the new ratio holds.

// File: rtl/clkdiv_pkg.sv
// Package: shared write-kind encoding and fixed control bit positions
// for the integer clock divider. Divider field positions depend on the
// divider width and are derived inside the modules.
package clkdiv_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } wr_op_e;

    localparam int GATE_BIT = 0;
    localparam int BYP_BIT  = 1;
    localparam int XDIV_LSB = 2;

endpackage

// File: rtl/clkdiv_regs.sv
// Module: clkdiv_regs
// Holds the control register {ref divider, xtal divider, bypass, gate}
// and applies plain/set/clear/toggle writes. Divider fields are frozen
// while the stored gate bit is 1. Raises busy on an accepted divider
// change and drops it when the engine reports the new setting applied.
// Assumes: applied is a one-cycle-or-longer level from the engine that
// is high in every cycle in which the engine samples the register.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int RST_XDIV = 1,
    parameter int RST_RDIV = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_op,
    input  logic [2+2*DIV_W-1:0]   wr_data,
    input  logic                   applied,
    output logic [2+2*DIV_W-1:0]   cfg_q,
    output logic                   busy
);
    localparam int REG_W    = 2 + 2*DIV_W;
    localparam int RDIV_LSB = XDIV_LSB + DIV_W;
    localparam logic [REG_W-1:0] DIV_MASK = {{(2*DIV_W){1'b1}}, 2'b00};
    localparam logic [REG_W-1:0] RST_VAL  =
        (REG_W'(RST_RDIV) << RDIV_LSB) | (REG_W'(RST_XDIV) << XDIV_LSB) |
        (REG_W'(1) << BYP_BIT);

    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] next_q;
    logic             gated;
    logic             div_chg;

    // Combine the write data with the stored value per write kind.
    always_comb begin
        case (wr_op)
            OP_SET:  merged = cfg_q | wr_data;
            OP_CLR:  merged = cfg_q & ~wr_data;
            OP_TOG:  merged = cfg_q ^ wr_data;
            default: merged = wr_data;
        endcase
    end

    // Keep divider fields when gated; flag an accepted divider change.
    always_comb begin
        gated   = cfg_q[GATE_BIT];
        next_q  = gated ? ((merged & ~DIV_MASK) | (cfg_q & DIV_MASK)) : merged;
        div_chg = !gated && ((merged & DIV_MASK) != (cfg_q & DIV_MASK));
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (wr_en) begin
            cfg_q <= next_q;
        end
    end

    // Busy flag: a new change wins over a same-cycle apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (wr_en && div_chg) begin
            busy <= 1'b1;
        end else if (applied) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/clkdiv_engine.sv
// Module: clkdiv_engine
// Counts ticks of the active source and emits one output pulse per
// completed period. The active source and divider are reloaded from the
// register only at a period end, while gated, or while the active
// divider is zero, so no period is ever cut short.
// Assumes: source ticks are single-cycle pulses on clk.
module clkdiv_engine #(
    parameter int DIV_W    = 6,
    parameter int RST_XDIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick,
    input  logic             ref_tick,
    input  logic             cfg_gate,
    input  logic             cfg_bypass,
    input  logic [DIV_W-1:0] cfg_xdiv,
    input  logic [DIV_W-1:0] cfg_rdiv,
    output logic             applied,
    output logic [DIV_W-1:0] act_div,
    output logic             act_sel,
    output logic             tick_out
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] next_div;
    logic             src_tk;
    logic             running;
    logic             last;

    // Pick the active source tick and detect the end of a period.
    always_comb begin
        src_tk   = act_sel ? xtal_tick : ref_tick;
        running  = (act_div != '0);
        last     = src_tk && running && (cnt == act_div - 1'b1);
        applied  = last || !running || cfg_gate;
        next_div = cfg_bypass ? cfg_xdiv : cfg_rdiv;
    end

    // Period counter, active setting reload and output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_div  <= DIV_W'(RST_XDIV);
            act_sel  <= 1'b1;
            tick_out <= 1'b0;
        end else begin
            tick_out <= last && !cfg_gate;
            if (applied) begin
                cnt     <= '0;
                act_div <= next_div;
                act_sel <= cfg_bypass;
            end else if (src_tk) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkdiv_bypass_top.sv
// Module: clkdiv_bypass_top
// Integer clock-enable divider with a crystal/reference bypass select,
// output gate, aliased register writes and a busy handshake on divider
// updates. Connects the register block to the counting engine.
// Assumes: all inputs are synchronous to clk.
module clkdiv_bypass_top
    import clkdiv_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int RST_XDIV = 1,
    parameter int RST_RDIV = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xtal_tick,
    input  logic                 ref_tick,
    input  logic                 wr_en,
    input  logic [1:0]           wr_op,
    input  logic [2+2*DIV_W-1:0] wr_data,
    output logic [2+2*DIV_W-1:0] rd_data,
    output logic                 busy,
    output logic                 tick_out
);
    localparam int RDIV_LSB = XDIV_LSB + DIV_W;

    logic             applied;
    logic [DIV_W-1:0] act_div;
    logic             act_sel;

    clkdiv_regs #(
        .DIV_W    (DIV_W),
        .RST_XDIV (RST_XDIV),
        .RST_RDIV (RST_RDIV)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .applied (applied),
        .cfg_q   (rd_data),
        .busy    (busy)
    );

    clkdiv_engine #(
        .DIV_W    (DIV_W),
        .RST_XDIV (RST_XDIV)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_tick  (xtal_tick),
        .ref_tick   (ref_tick),
        .cfg_gate   (rd_data[GATE_BIT]),
        .cfg_bypass (rd_data[BYP_BIT]),
        .cfg_xdiv   (rd_data[XDIV_LSB +: DIV_W]),
        .cfg_rdiv   (rd_data[RDIV_LSB +: DIV_W]),
        .applied    (applied),
        .act_div    (act_div),
        .act_sel    (act_sel),
        .tick_out   (tick_out)
    );

endmodule

// File: rtl/clkdiv_bypass_chk.sv
// Module: clkdiv_bypass_chk
// Property checker for clkdiv_bypass_top, bound to every instance.
// Assumes: the top exposes applied, act_div and act_sel internally.
module clkdiv_bypass_chk #(
    parameter int DIV_W = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_op,
    input logic [2+2*DIV_W-1:0] wr_data,
    input logic [2+2*DIV_W-1:0] rd_data,
    input logic                 busy,
    input logic                 tick_out,
    input logic                 applied,
    input logic [DIV_W-1:0]     act_div,
    input logic                 act_sel
);
    localparam int REG_W = 2 + 2*DIV_W;

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> ($past(act_div) != '0));  // R2

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> !$past(rd_data[0]));  // R5

    AST_GATED_DIV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[0]) |=> (rd_data[REG_W-1:2] == $past(rd_data[REG_W-1:2])));  // R4

    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && !rd_data[0]));  // R3

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !applied) |=> busy);  // R3

    AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_sel) && $past(!rd_data[0] && act_div != '0)) |-> tick_out);  // R8

    AST_SET_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd1 && wr_data[1]) |=> rd_data[1]);  // R7

    AST_TOG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd3 && wr_data[1]) |=> (rd_data[1] != $past(rd_data[1])));  // R7

endmodule

bind clkdiv_bypass_top clkdiv_bypass_chk #(.DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_clkdiv_bypass_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, the monitor task
// pops each one and compares it with what the design produced.
module test_clkdiv_bypass_top;
    localparam int DIV_W = 6;
    localparam int REG_W = 2 + 2*DIV_W;
    localparam int XS    = 3;   // crystal tick spacing in cycles
    localparam int RS    = 2;   // reference tick spacing in cycles

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xtal_tick = 1'b0;
    logic             ref_tick = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_op = 2'd0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             busy;
    logic             tick_out;

    int checks = 0;
    int errors = 0;
    int ph_x = 0;
    int ph_r = 0;

    typedef struct {
        string req;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    clkdiv_bypass_top #(.DIV_W(DIV_W)) i_clkdiv_bypass_top (
        .clk (clk), .rst_n (rst_n), .xtal_tick (xtal_tick), .ref_tick (ref_tick),
        .wr_en (wr_en), .wr_op (wr_op), .wr_data (wr_data),
        .rd_data (rd_data), .busy (busy), .tick_out (tick_out)
    );

    always #2.5 clk = ~clk;

    // Source pulse generators, driven away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            ph_x = (ph_x + 1) % XS;
            ph_r = (ph_r + 1) % RS;
            xtal_tick = (ph_x == 0);
            ref_tick  = (ph_r == 0);
        end
    end

    function automatic logic [REG_W-1:0] mk(int rdiv, int xdiv, int byp, int gate);
        return (REG_W'(rdiv) << (2 + DIV_W)) | (REG_W'(xdiv) << 2) |
               (REG_W'(byp) << 1) | REG_W'(gate);
    endfunction

    task automatic sb_expect(string req, int val);
        exp_t e;
        e.req = req;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic sb_observe(string what, int act);
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (act != e.val) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", e.req, what, act, e.val);
        end
    endtask

    task automatic do_write(logic [1:0] op, logic [REG_W-1:0] data);
        wr_op = op;
        wr_data = data;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait for the next output tick (seen at a negedge).
    task automatic wait_tick(output int ok);
        ok = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tick_out) begin
                ok = 1;
                break;
            end
        end
    endtask

    // Interval from the next output tick to the one after it.
    task automatic next_interval(output int n);
        int ok;
        n = 0;
        wait_tick(ok);
        if (ok == 1) begin
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                n++;
                if (tick_out) break;
            end
        end
    endtask

    task automatic count_ticks(int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_out) n++;
        end
    endtask

    task automatic wait_busy_low(int limit, output int cyc);
        cyc = 0;
        while (busy && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        sb_expect("R9", int'(mk(1, 1, 1, 0))); sb_observe("reset readback", int'(rd_data));
        sb_expect("R9", 0); sb_observe("reset busy", int'(busy));
        sb_expect("R9", 0); sb_observe("reset tick", int'(tick_out));

        // R1 default crystal divide by one
        next_interval(n);
        sb_expect("R1", 1 * XS); sb_observe("period xtal div1", n);

        // R3 busy on divider change, R1 divide by four
        do_write(2'd0, mk(3, 4, 1, 0));
        sb_expect("R3", 1); sb_observe("busy after write", int'(busy));
        wait_busy_low(40, n);
        sb_expect("R3", 0); sb_observe("busy cleared", int'(busy));
        next_interval(n);
        sb_expect("R1", 4 * XS); sb_observe("period xtal div4", n);
        wait_tick(ok);
        count_ticks(5 * 4 * XS, n);
        sb_expect("R1", 5); sb_observe("ticks in window", n);

        // R7 clear alias on bypass, R6 reference field, R8 switch at end
        do_write(2'd2, REG_W'(2));
        sb_expect("R7", int'(mk(3, 4, 0, 0))); sb_observe("clear bypass readback", int'(rd_data));
        next_interval(n);
        sb_expect("R8", 1); sb_observe($sformatf("first ref interval %0d", n),
                                       int'(n >= 2*RS + 1 && n <= 3*RS));
        next_interval(n);
        sb_expect("R6", 3 * RS); sb_observe("period ref div3", n);

        // R7 toggle alias back to crystal, R8 first interval, R6 crystal field
        do_write(2'd3, REG_W'(2));
        sb_expect("R7", int'(mk(3, 4, 1, 0))); sb_observe("toggle bypass readback", int'(rd_data));
        next_interval(n);
        sb_expect("R8", 1); sb_observe($sformatf("first xtal interval %0d", n),
                                       int'(n >= 3*XS + 1 && n <= 4*XS));
        next_interval(n);
        sb_expect("R6", 4 * XS); sb_observe("period xtal div4 again", n);

        // R5 gate, R4 divider write refused while gated
        do_write(2'd1, REG_W'(1));
        sb_expect("R7", int'(mk(3, 4, 1, 1))); sb_observe("set gate readback", int'(rd_data));
        count_ticks(60, n);
        sb_expect("R5", 0); sb_observe("ticks while gated", n);
        do_write(2'd0, mk(3, 2, 1, 1));
        sb_expect("R4", int'(mk(3, 4, 1, 1))); sb_observe("gated write readback", int'(rd_data));
        sb_expect("R4", 0); sb_observe("busy after gated write", int'(busy));
        do_write(2'd2, REG_W'(1));
        next_interval(n);
        sb_expect("R4", 4 * XS); sb_observe("period after ungate", n);

        // R2 zero divider
        do_write(2'd0, mk(3, 0, 1, 0));
        wait_busy_low(40, n);
        sb_expect("R3", 0); sb_observe("busy cleared for zero", int'(busy));
        count_ticks(60, n);
        sb_expect("R2", 0); sb_observe("ticks with zero divider", n);
        do_write(2'd0, mk(3, 2, 1, 0));
        @(negedge clk);
        sb_expect("R3", 0); sb_observe("busy quick clear from zero", int'(busy));
        next_interval(n);
        sb_expect("R1", 2 * XS); sb_observe("period xtal div2", n);

        // R3/R8 collision: divider write on the period-end edge
        wait_tick(ok);
        repeat (2 * XS - 1) @(negedge clk);
        wr_op = 2'd0;
        wr_data = mk(3, 3, 1, 0);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        sb_expect("R8", 1); sb_observe("tick on collision edge", int'(tick_out));
        sb_expect("R3", 1); sb_observe("busy after collision", int'(busy));
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (tick_out) break;
        end
        sb_expect("R3", 2 * XS); sb_observe("old divider kept one period", n);
        sb_expect("R3", 0); sb_observe("busy at next period end", int'(busy));
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (tick_out) break;
        end
        sb_expect("R1", 3 * XS); sb_observe("period xtal div3", n);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule